// File: doc/BRIEF.md
# Cascaded Line Delay Tap Generator

This block turns a single incoming sample stream into several taps of the same stream, each one line further delayed, and presents them side by side on separate buses. One line is `LINE_WORDS` words. The block holds three banks of line storage, and the middle bank is split into two half-width halves. A configuration input decides how the banks are strung together. The three banks can form an 8-bit chain with three taps. Two banks can form an 8-bit chain with two taps, leaving the third bank as an independent auxiliary delay channel. Or all the storage can form a 12-bit chain with two taps.

Only the first stage has a write port that is driven from outside. Every later stage is filled from the word the stage before it reads out, on the same edge. Every read and write of the later stages follows the first stage's read enable and read clear, so the taps stay aligned and no wiring outside the block is needed.

The read side of each chain is controlled by a three-state machine, with states RD_QUIET, RD_DRIVE and RD_CLEAR. A read-clear request moves it to RD_CLEAR (the pointers are cleared and the outputs are off). Otherwise, a read enable moves it to RD_DRIVE (the taps carry data). Otherwise it moves to RD_QUIET (the taps are off). The transitions depend only on the inputs of the current cycle, so any state can reach any other state. The design uses one clock, and the write and read controls are enables within that clock.

Top module: `line_tap_chain`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every drive-enable output (`tap1_oe`, `tap2_oe`, `tap3_oe`, `aux_oe`) is 0 and every data output is 0.
- R2: Suppose the write clear and the read clear are both given in one cycle, and from the next cycle on the write and read enables are high in every cycle. Then `tap1` shows the input word written exactly `LINE_WORDS` cycles earlier. When the read address equals the write address, the old word is read, and the new word is stored.
- R3: Suppose the read enable is held low for n cycles (1 ≤ n ≤ `LINE_WORDS`) after a joint clear, while writing continues. Then `tap1` is delayed by n words, tap 2 by n + `LINE_WORDS` words and tap 3 by n + 2·`LINE_WORDS` words.
- R4: A cycle with `line_rd_en`=1 and `line_rd_clr`=0 makes every active tap of the chain drive on the next cycle (drive-enable 1). Each later stage adds exactly `LINE_WORDS` words of delay to the stage before it.
- R5: A cycle with `line_rd_en`=0 and no clear turns off the chain taps on the next cycle (drive-enable 0, data 0). No pointer in the chain moves and no later stage is written, so the delay relation carries on unchanged once reading resumes.
- R6: `line_rd_clr`=1 clears the first stage's read pointer and both the write pointer and the read pointer of every later stage. It takes priority over `line_rd_en`, and the taps are off on the next cycle.
- R7: `line_wr_en`=1 stores `line_in` at the write pointer and advances the pointer. `line_wr_clr`=1 returns the pointer to 0 and suppresses the store. The first read after a joint clear therefore returns the first word written after it.
- R8: With `cfg`=0 there are three 8-bit taps. The stage-1 and stage-2 words are on bits [7:0] of `tap1` and `tap2`, bits [11:8] read 0, and `line_in[11:8]` is ignored.
- R9: With `cfg`=2 the chain is 12 bits wide with two taps, taking the full `line_in[11:0]` and giving it out on `tap1` and `tap2`. `tap3_oe` and `tap3` stay 0.
- R10: With `cfg`=1 there are two 8-bit taps, and the third bank is an auxiliary single-stage delay channel with its own write and read enables and clears. This channel keeps running while the chain is paused. `tap3_oe` stays 0.
- R11: With `cfg` other than 1, the auxiliary controls have no effect. `aux_oe` and `aux_out` stay 0, and the three-tap chain is undisturbed by them.
- R12: `cfg`=3 behaves exactly like `cfg`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all storage and control |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 2 | Chain arrangement: 0/3 three 8-bit taps, 1 two 8-bit taps plus auxiliary channel, 2 two 12-bit taps |
| line_in | input | 12 | Input word of the chain (bits [7:0] used in the 8-bit arrangements) |
| line_wr_en | input | 1 | Store `line_in` and advance the write pointer |
| line_wr_clr | input | 1 | Clear the first-stage write pointer |
| line_rd_en | input | 1 | Read all stages and advance the chain pointers |
| line_rd_clr | input | 1 | Clear all chain read pointers and later-stage write pointers |
| tap1 | output | 12 | One-line-delayed word |
| tap1_oe | output | 1 | `tap1` is driven |
| tap2 | output | 12 | Two-line-delayed word |
| tap2_oe | output | 1 | `tap2` is driven |
| tap3 | output | 8 | Three-line-delayed word (`cfg`=0/3 only) |
| tap3_oe | output | 1 | `tap3` is driven |
| aux_in | input | 8 | Auxiliary channel input word |
| aux_wr_en | input | 1 | Auxiliary store and advance |
| aux_wr_clr | input | 1 | Auxiliary write pointer clear |
| aux_rd_en | input | 1 | Auxiliary read and advance |
| aux_rd_clr | input | 1 | Auxiliary read pointer clear |
| aux_out | output | 8 | Auxiliary channel output word |
| aux_oe | output | 1 | `aux_out` is driven |

## Verification
The bench sweeps every arrangement with a read start delayed by 0, small and full-line amounts. It computes each tap's expected word from the index of the sample that should have reached it. The cases it targets are these:
- Read-before-write collisions at zero offset. A write-first array would give a delay of zero instead of one line.
- Pauses in the middle of a stream. A later stage written while the chain is disabled would corrupt its line, so the check on tap 2 or tap 3 fails after the pause.
- Clears given together with enables. A read that was not suppressed would switch a tap on during the clear cycle.
- The auxiliary channel running through a chain pause. A shared controller would stall the auxiliary channel or shift its delay.
- Upper input bits changing in the 8-bit arrangements. A routing error would leak them into the taps.

// File: rtl/ltc_pkg.sv
package ltc_pkg;

    typedef enum logic [1:0] {
        CFG_TRIPLE     = 2'd0,
        CFG_PAIR_AUX   = 2'd1,
        CFG_PAIR_WIDE  = 2'd2,
        CFG_TRIPLE_ALT = 2'd3
    } chain_cfg_e;

    typedef enum logic [1:0] {
        RD_QUIET = 2'd0,
        RD_DRIVE = 2'd1,
        RD_CLEAR = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic three_stage;
        logic wide;
        logic aux_live;
    } route_t;

    function automatic route_t decode_cfg(input logic [1:0] code);
        route_t r;
        r.three_stage = 1'b0;
        r.wide        = 1'b0;
        r.aux_live    = 1'b0;
        unique case (chain_cfg_e'(code))
            CFG_TRIPLE, CFG_TRIPLE_ALT: r.three_stage = 1'b1;
            CFG_PAIR_AUX:               r.aux_live    = 1'b1;
            CFG_PAIR_WIDE:              r.wide        = 1'b1;
            default:                    r.three_stage = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ltc_bank.sv
module ltc_bank #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cells [DEPTH];

    // Asynchronous read: a same-edge write lands after the read is sampled,
    // so a colliding address returns the previous word.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/ltc_ptr.sv
module ltc_ptr #(
    parameter int DEPTH = 16,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          advance,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clear) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ptr == '0)) else $error("pointer not cleared");       // R6
    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> $stable(ptr)) else $error("pointer moved"); // R5
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST) else $error("pointer beyond line");                  // R2

endmodule

// File: rtl/ltc_read_fsm.sv
module ltc_read_fsm
    import ltc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    input  logic rd_en,
    input  logic rd_clr,
    output logic step,
    output logic clear,
    output logic oe
);

    rd_state_e state_q;
    rd_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: any state -> RD_CLEAR on clear, -> RD_DRIVE on enable,
    // otherwise -> RD_QUIET; a channel that is not allowed always goes quiet.
    always_comb begin
        state_d = RD_QUIET;
        unique case (state_q)
            RD_QUIET, RD_DRIVE, RD_CLEAR: begin
                if (allow && rd_clr) begin
                    state_d = RD_CLEAR;
                end else if (allow && rd_en) begin
                    state_d = RD_DRIVE;
                end
            end
            default: state_d = RD_QUIET;
        endcase
    end

    always_comb begin
        step  = allow && rd_en && !rd_clr;
        clear = allow && rd_clr;
        unique case (state_q)
            RD_DRIVE:           oe = 1'b1;
            RD_QUIET, RD_CLEAR: oe = 1'b0;
            default:            oe = 1'b0;
        endcase
    end

    AST_CHAIN_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> oe) else $error("read did not drive");      // R4
    AST_CHAIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !oe) else $error("drive without read");     // R5

endmodule

// File: rtl/line_tap_chain.sv
module line_tap_chain
    import ltc_pkg::*;
#(
    parameter int LINE_WORDS = 16,
    parameter int NARROW_W   = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [1:0]                           cfg,
    input  logic [NARROW_W+NARROW_W/2-1:0]       line_in,
    input  logic                                 line_wr_en,
    input  logic                                 line_wr_clr,
    input  logic                                 line_rd_en,
    input  logic                                 line_rd_clr,
    output logic [NARROW_W+NARROW_W/2-1:0]       tap1,
    output logic                                 tap1_oe,
    output logic [NARROW_W+NARROW_W/2-1:0]       tap2,
    output logic                                 tap2_oe,
    output logic [NARROW_W-1:0]                  tap3,
    output logic                                 tap3_oe,
    input  logic [NARROW_W-1:0]                  aux_in,
    input  logic                                 aux_wr_en,
    input  logic                                 aux_wr_clr,
    input  logic                                 aux_rd_en,
    input  logic                                 aux_rd_clr,
    output logic [NARROW_W-1:0]                  aux_out,
    output logic                                 aux_oe
);

    localparam int NIB_W  = NARROW_W / 2;
    localparam int WIDE_W = NARROW_W + NIB_W;
    localparam int AW     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;

    route_t route;
    assign route = decode_cfg(cfg);

    // ---------------- first-stage write side ----------------
    logic          line_we;
    logic [AW-1:0] wptr;
    assign line_we = line_wr_en && !line_wr_clr;

    ltc_ptr #(.DEPTH(LINE_WORDS), .AW(AW)) u_wptr (
        .clk(clk), .rst_n(rst_n), .clear(line_wr_clr), .advance(line_we), .ptr(wptr)
    );

    // ---------------- chain read side ----------------
    logic          chain_step, chain_clear, chain_oe;
    logic [AW-1:0] cptr;

    ltc_read_fsm u_chain_fsm (
        .clk(clk), .rst_n(rst_n), .allow(1'b1), .rd_en(line_rd_en), .rd_clr(line_rd_clr),
        .step(chain_step), .clear(chain_clear), .oe(chain_oe)
    );

    // One pointer serves the reads of every stage and the writes of every
    // later stage: they clear and advance on identical conditions.
    ltc_ptr #(.DEPTH(LINE_WORDS), .AW(AW)) u_cptr (
        .clk(clk), .rst_n(rst_n), .clear(chain_clear), .advance(chain_step), .ptr(cptr)
    );

    // ---------------- auxiliary channel control ----------------
    logic          aux_we, aux_wclear, aux_step, aux_clear, aux_fsm_oe;
    logic [AW-1:0] aux_wptr, aux_rptr;
    assign aux_we     = route.aux_live && aux_wr_en && !aux_wr_clr;
    assign aux_wclear = route.aux_live && aux_wr_clr;

    ltc_ptr #(.DEPTH(LINE_WORDS), .AW(AW)) u_aux_wptr (
        .clk(clk), .rst_n(rst_n), .clear(aux_wclear), .advance(aux_we), .ptr(aux_wptr)
    );

    ltc_read_fsm u_aux_fsm (
        .clk(clk), .rst_n(rst_n), .allow(route.aux_live), .rd_en(aux_rd_en), .rd_clr(aux_rd_clr),
        .step(aux_step), .clear(aux_clear), .oe(aux_fsm_oe)
    );

    ltc_ptr #(.DEPTH(LINE_WORDS), .AW(AW)) u_aux_rptr (
        .clk(clk), .rst_n(rst_n), .clear(aux_clear), .advance(aux_step), .ptr(aux_rptr)
    );

    // ---------------- bank routing ----------------
    logic [NARROW_W-1:0] m0_wd, m0_rd, m2_wd, m2_rd;
    logic [NIB_W-1:0]    m1l_wd, m1l_rd, m1h_wd, m1h_rd;
    logic                m1l_we, m2_we;
    logic [AW-1:0]       m1l_wa, m2_wa, m2_ra;

    always_comb begin
        // bank 0: always the first stage (upper 8 bits of a wide word)
        m0_wd  = route.wide ? line_in[WIDE_W-1:NIB_W] : line_in[NARROW_W-1:0];
        // bank 1 low half: first-stage low nibble (wide) or stage 2 (narrow)
        m1l_we = route.wide ? line_we : chain_step;
        m1l_wa = route.wide ? wptr : cptr;
        m1l_wd = route.wide ? line_in[NIB_W-1:0] : m0_rd[NIB_W-1:0];
        // bank 1 high half: always a later stage
        m1h_wd = route.wide ? m1l_rd : m0_rd[NARROW_W-1:NIB_W];
        // bank 2: third stage, second wide stage, or auxiliary channel
        if (route.aux_live) begin
            m2_we = aux_we;
            m2_wa = aux_wptr;
            m2_ra = aux_rptr;
            m2_wd = aux_in;
        end else begin
            m2_we = chain_step;
            m2_wa = cptr;
            m2_ra = cptr;
            m2_wd = route.wide ? m0_rd : {m1h_rd, m1l_rd};
        end
    end

    ltc_bank #(.DEPTH(LINE_WORDS), .W(NARROW_W), .AW(AW)) u_bank0 (
        .clk(clk), .we(line_we), .waddr(wptr), .wdata(m0_wd), .raddr(cptr), .rdata(m0_rd)
    );
    ltc_bank #(.DEPTH(LINE_WORDS), .W(NIB_W), .AW(AW)) u_bank1_lo (
        .clk(clk), .we(m1l_we), .waddr(m1l_wa), .wdata(m1l_wd), .raddr(cptr), .rdata(m1l_rd)
    );
    ltc_bank #(.DEPTH(LINE_WORDS), .W(NIB_W), .AW(AW)) u_bank1_hi (
        .clk(clk), .we(chain_step), .waddr(cptr), .wdata(m1h_wd), .raddr(cptr), .rdata(m1h_rd)
    );
    ltc_bank #(.DEPTH(LINE_WORDS), .W(NARROW_W), .AW(AW)) u_bank2 (
        .clk(clk), .we(m2_we), .waddr(m2_wa), .wdata(m2_wd), .raddr(m2_ra), .rdata(m2_rd)
    );

    // ---------------- output registers ----------------
    logic [WIDE_W-1:0]   tap1_q, tap2_q;
    logic [NARROW_W-1:0] tap3_q, aux_q;
    logic                tap3_oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap1_q    <= '0;
            tap2_q    <= '0;
            tap3_q    <= '0;
            tap3_oe_q <= 1'b0;
        end else if (chain_step) begin
            tap1_q    <= route.wide ? {m0_rd, m1l_rd} : WIDE_W'(m0_rd);
            tap2_q    <= route.wide ? {m2_rd, m1h_rd} : WIDE_W'({m1h_rd, m1l_rd});
            tap3_q    <= route.three_stage ? m2_rd : '0;
            tap3_oe_q <= route.three_stage;
        end else begin
            tap1_q    <= '0;
            tap2_q    <= '0;
            tap3_q    <= '0;
            tap3_oe_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aux_q <= '0;
        end else begin
            aux_q <= aux_step ? m2_rd : '0;
        end
    end

    assign tap1    = tap1_q;
    assign tap2    = tap2_q;
    assign tap3    = tap3_q;
    assign tap1_oe = chain_oe;
    assign tap2_oe = chain_oe;
    assign tap3_oe = tap3_oe_q;
    assign aux_out = aux_q;
    assign aux_oe  = aux_fsm_oe;

    AST_TAP3_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !route.three_stage |=> !tap3_oe) else $error("tap3 driven in two-tap arrangement"); // R9
    AST_AUX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !route.aux_live |=> (!aux_oe && aux_out == '0)) else $error("aux active");       // R11
    AST_CLEAR_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        line_rd_clr |=> (!tap1_oe && !tap3_oe)) else $error("taps driven after clear");  // R6

endmodule

// File: tb/line_tap_chain_bench.sv
`timescale 1ns/1ps
module line_tap_chain_bench;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg = 2'd0;
    logic [11:0] line_in = '0;
    logic        line_wr_en = 1'b0, line_wr_clr = 1'b0, line_rd_en = 1'b0, line_rd_clr = 1'b0;
    logic [11:0] tap1, tap2;
    logic [7:0]  tap3, aux_out;
    logic        tap1_oe, tap2_oe, tap3_oe, aux_oe;
    logic [7:0]  aux_in = '0;
    logic        aux_wr_en = 1'b0, aux_wr_clr = 1'b0, aux_rd_en = 1'b0, aux_rd_clr = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    line_tap_chain #(.LINE_WORDS(D), .NARROW_W(8)) u_line_tap_chain (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .line_in(line_in),
        .line_wr_en(line_wr_en), .line_wr_clr(line_wr_clr),
        .line_rd_en(line_rd_en), .line_rd_clr(line_rd_clr),
        .tap1(tap1), .tap1_oe(tap1_oe), .tap2(tap2), .tap2_oe(tap2_oe),
        .tap3(tap3), .tap3_oe(tap3_oe),
        .aux_in(aux_in), .aux_wr_en(aux_wr_en), .aux_wr_clr(aux_wr_clr),
        .aux_rd_en(aux_rd_en), .aux_rd_clr(aux_rd_clr),
        .aux_out(aux_out), .aux_oe(aux_oe)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int pat(input int k, input int salt);
        return (k * 37 + salt * 101 + 5) & 'hFFF;
    endfunction

    // One run: joint clear (enables also high, clears must win), then a
    // stream with read start delayed by n, an optional 3-cycle chain pause,
    // and the auxiliary channel streaming with read delay na throughout.
    task automatic run_stream(input int cv, input int n, input int len, input int pause_at,
                              input int na, input int salt);
        int j = 0;
        int ja = 0;
        int eff = (n == 0) ? D : n;
        int effa = (na == 0) ? D : na;
        bit wide = (cv == 2);
        bit three = (cv == 0) || (cv == 3);
        bit auxl = (cv == 1);
        int mask = wide ? 'hFFF : 'hFF;
        string r2s = (cv == 0) ? "R8" : (cv == 2) ? "R9" : (cv == 1) ? "R10" : "R12";
        @(negedge clk);
        cfg = cv[1:0];
        line_wr_clr = 1'b1; line_rd_clr = 1'b1; line_wr_en = 1'b1; line_rd_en = 1'b1;
        aux_wr_clr = 1'b1; aux_rd_clr = 1'b1; aux_wr_en = 1'b1; aux_rd_en = 1'b1;
        @(posedge clk); #1;
        chk(!tap1_oe && !tap2_oe && !tap3_oe, "R6", "taps off after clear", int'(tap1_oe), 0);
        chk(!aux_oe, "R6", "aux off after clear", int'(aux_oe), 0);
        for (int t = 0; t < len + 3; t++) begin
            bit paused = (pause_at >= 0) && (t >= pause_at) && (t < pause_at + 3);
            @(negedge clk);
            line_wr_clr = 1'b0; line_rd_clr = 1'b0; aux_wr_clr = 1'b0; aux_rd_clr = 1'b0;
            if (paused) begin
                line_wr_en = 1'b0; line_rd_en = 1'b0;
                line_in = 12'(pat(t + 999, salt));
            end else begin
                line_wr_en = 1'b1;
                line_rd_en = (j >= n);
                line_in = 12'(pat(j, salt));
            end
            aux_wr_en = 1'b1;
            aux_rd_en = (ja >= na);
            aux_in = 8'(pat(ja, salt + 7));
            @(posedge clk); #1;
            if (paused || j < n) begin
                chk(!tap1_oe && !tap2_oe && tap1 == 0 && tap2 == 0,
                    paused ? "R5" : "R4", "taps quiet while not reading", int'(tap1), 0);
            end else begin
                int i = j - n;
                int e1 = i + n - eff;
                chk(tap1_oe && tap2_oe, "R4", "taps driven", int'(tap1_oe), 1);
                if (e1 >= 0)
                    chk(int'(tap1) == (pat(e1, salt) & mask),
                        (i == 0 && n > 0) ? "R7" : (n == 0) ? "R2" : "R3",
                        "tap1 word", int'(tap1), pat(e1, salt) & mask);
                if (e1 - D >= 0)
                    chk(int'(tap2) == (pat(e1 - D, salt) & mask), r2s, "tap2 word",
                        int'(tap2), pat(e1 - D, salt) & mask);
                if (three) begin
                    chk(tap3_oe, r2s, "tap3 driven", int'(tap3_oe), 1);
                    if (e1 - 2 * D >= 0)
                        chk(int'(tap3) == (pat(e1 - 2 * D, salt) & 'hFF), r2s, "tap3 word",
                            int'(tap3), pat(e1 - 2 * D, salt) & 'hFF);
                end
            end
            if (!three)
                chk(!tap3_oe && tap3 == 0, wide ? "R9" : "R10", "tap3 quiet", int'(tap3), 0);
            if (auxl) begin
                if (ja >= na) begin
                    int ea = ja - na + na - effa;
                    chk(aux_oe, "R10", "aux driven", int'(aux_oe), 1);
                    if (ea >= 0)
                        chk(int'(aux_out) == (pat(ea, salt + 7) & 'hFF), "R10", "aux word",
                            int'(aux_out), pat(ea, salt + 7) & 'hFF);
                end else begin
                    chk(!aux_oe, "R10", "aux quiet before read start", int'(aux_oe), 0);
                end
            end else begin
                chk(!aux_oe && aux_out == 0, "R11", "aux ignored", int'(aux_out), 0);
            end
            if (!paused) j++;
            ja++;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!tap1_oe && !tap2_oe && !tap3_oe && !aux_oe, "R1", "oe in reset", int'(tap1_oe), 0);
        chk(tap1 == 0 && tap2 == 0 && tap3 == 0 && aux_out == 0, "R1", "data in reset", int'(tap1), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!tap1_oe && !tap3_oe && !aux_oe && tap1 == 0, "R1", "first cycle after reset", int'(tap1_oe), 0);
        run_stream(0, 0, 5 * D, -1, 2, 1);
        run_stream(0, 5, 5 * D, 40, 0, 2);
        run_stream(2, 3, 4 * D, 30, 3, 3);
        run_stream(1, 0, 4 * D, 25, 4, 4);
        run_stream(1, D, 4 * D, 50, 0, 5);
        run_stream(3, 7, 4 * D, 45, 1, 6);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule